// File: doc/BRIEF.md
# Three-Stage Pipelined ALU Core

This block is a small register-to-register processor core. It runs a program held in a parameter-initialised instruction ROM through three overlapped stages. In the fetch stage the instruction at the program counter is decoded and its source registers are read. In the execute stage the ALU computes a result and a set of flags. In the writeback stage the result is committed to an eight-entry register file. Only ALU operations and a branch-if-zero are supported, and there are no memory accesses.

There are no forwarding paths. A dependent instruction waits in the fetch stage until its producer has written the register file. Branches are predicted not taken. A branch-if-zero is resolved in the execute stage from the ALU zero flag. When the branch is taken, the sequential instruction that was fetched behind it is squashed and the program counter is loaded with the target. The register-file write port, a retire strobe and the flags of the retiring instruction are brought out so that a checker can follow the program at instruction granularity.

Top module: `pipe3_core`

## Requirements
- R1: An instruction that leaves the fetch stage in cycle t is in execute in t+1 and retires in t+2. Four independent instructions therefore retire in the first six cycles, and once the pipeline is full one instruction retires per cycle.
- R2: Reset clears every register to zero, and no retire or write happens while reset is held. A write made in the writeback cycle becomes readable in the fetch stage only from the next cycle.
- R3: An instruction that reads the destination of the instruction just ahead of it is held two cycles. If the producer is two places ahead, it is held one cycle. It then reads the new value.
- R4: While the fetch stage is held, the program counter and the fetched instruction do not change and a bubble goes into execute. A bubble never retires.
- R5: A dependency exists only when the older instruction has its write enable set. Branches, no-ops and bubbles never cause a stall, whatever their destination field holds.
- R6: A branch-if-zero whose source register is zero is taken in its execute cycle. The instruction fetched behind it is squashed, and the target is in the fetch stage in the next cycle. The branch itself retires with the write disabled.
- R7: A branch-if-zero whose source is non-zero is not taken. The sequential instruction after it continues with no lost cycle.
- R8: The instruction word is 16 bits: opcode [15:12], destination [11:9], source A [8:6], source B [5:3], and a 6-bit immediate or absolute branch target [5:0]. The opcodes are 0 no-op, 1 add, 2 subtract, 3 and, 4 or, 5 xor, 6 add zero-extended immediate, and 7 branch if source A is zero.
- R9: The retire flags are V, C, N, Z in bits 3 to 0. C is the carry-out for additions and the borrow for subtraction, and it is 0 for logic operations. V is the signed overflow, N is the result MSB and Z marks a zero result.
- R10: The retire strobe pulses once for each instruction that is not a bubble. The write enable is asserted only together with the retire strobe, and only for instructions that write a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_we | output | 1 | Register-file write enable (writeback stage) |
| rf_waddr | output | 3 | Register being written |
| rf_wdata | output | DATA_W | Value being written |
| retire | output | 1 | A non-bubble instruction leaves writeback this cycle |
| retire_flags | output | 4 | V, C, N, Z of the retiring instruction |

## Verification
The bench runs one program and compares the whole retire stream, cycle by cycle, against a timeline worked out by hand. The program covers a back-to-back dependency and a dependency one instruction apart. A design that stalls for the wrong number of cycles shifts every later retirement, and one without the stall retires stale sums. The program also covers a taken branch with a poisoned instruction behind it, which a design without the squash would let write r7. A not-taken branch that waits on its own source is included, and so is a write-disabled branch whose destination field names the next instruction's source, where a design that ignores the write enable would stall for no reason. Carry, borrow and signed-overflow results check the flag encoding.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

  localparam int INSTR_W = 16;
  localparam int RA_W    = 3;
  localparam int IMM_W   = 6;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_ADDI = 4'd6,
    OP_BZ   = 4'd7
  } op_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;

  typedef struct packed {
    op_e             op;
    logic [RA_W-1:0] rd;
    logic [RA_W-1:0] ra;
    logic [RA_W-1:0] rb;
    logic [IMM_W-1:0] imm;
    logic            use_a;
    logic            use_b;
    logic            wen;
  } dec_t;

  // Field split and per-opcode operand usage; unknown codes become no-ops.
  function automatic dec_t decode(input logic [INSTR_W-1:0] ins);
    dec_t d;
    d.op    = OP_NOP;
    d.rd    = ins[11:9];
    d.ra    = ins[8:6];
    d.rb    = ins[5:3];
    d.imm   = ins[5:0];
    d.use_a = 1'b0;
    d.use_b = 1'b0;
    d.wen   = 1'b0;
    case (ins[15:12])
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin
        d.op = op_e'(ins[15:12]);
        d.use_a = 1'b1; d.use_b = 1'b1; d.wen = 1'b1;
      end
      4'd6: begin
        d.op = OP_ADDI; d.use_a = 1'b1; d.wen = 1'b1;
      end
      4'd7: begin
        d.op = OP_BZ; d.use_a = 1'b1;
      end
      default: d.op = OP_NOP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pipe3_rf.sv
module pipe3_rf #(
  parameter int W = 8,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // No write-to-read bypass: a value written this cycle is seen next cycle.
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pipe3_alu.sv
module pipe3_alu
  import pipe3_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output flags_t       flags
);

  function automatic logic [W+3:0] alu_fn(input op_e f_op, input logic [W-1:0] fa,
                                          input logic [W-1:0] fb);
    logic [W:0]   s;
    logic [W-1:0] r;
    flags_t       f;
    s = '0;
    f = '0;
    case (f_op)
      OP_ADD, OP_ADDI: begin
        s   = {1'b0, fa} + {1'b0, fb};
        r   = s[W-1:0];
        f.c = s[W];
        f.v = (fa[W-1] == fb[W-1]) && (r[W-1] != fa[W-1]);
      end
      OP_SUB: begin
        s   = {1'b0, fa} - {1'b0, fb};
        r   = s[W-1:0];
        f.c = s[W];
        f.v = (fa[W-1] != fb[W-1]) && (r[W-1] != fa[W-1]);
      end
      OP_AND:  r = fa & fb;
      OP_OR:   r = fa | fb;
      OP_XOR:  r = fa ^ fb;
      default: r = fa;
    endcase
    f.n = r[W-1];
    f.z = (r == '0);
    return {f, r};
  endfunction

  assign {flags, y} = alu_fn(op, a, b);

endmodule

// File: rtl/pipe3_hazard.sv
module pipe3_hazard
  import pipe3_pkg::*;
(
  input  logic            use_a,
  input  logic            use_b,
  input  logic [RA_W-1:0] ra,
  input  logic [RA_W-1:0] rb,
  input  logic            ex_busy,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            wb_busy,
  input  logic [RA_W-1:0] wb_rd,
  output logic            stall
);

  function automatic logic pending(input logic [RA_W-1:0] r, input logic eb,
                                   input logic [RA_W-1:0] er, input logic wbb,
                                   input logic [RA_W-1:0] wr);
    return (eb && er == r) || (wbb && wr == r);
  endfunction

  logic hit_a, hit_b;
  assign hit_a = use_a && pending(ra, ex_busy, ex_rd, wb_busy, wb_rd);
  assign hit_b = use_b && pending(rb, ex_busy, ex_rd, wb_busy, wb_rd);
  assign stall = hit_a || hit_b;

endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NREGS      = 8,
  parameter int IMEM_DEPTH = 64,
  parameter logic [IMEM_DEPTH*INSTR_W-1:0] ROM_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              retire,
  output logic [3:0]        retire_flags
);

  localparam int PC_W = $clog2(IMEM_DEPTH);

  typedef struct packed {
    logic              valid;
    op_e               op;
    logic [RA_W-1:0]   rd;
    logic              wen;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic [PC_W-1:0]   tgt;
  } ex_t;

  typedef struct packed {
    logic              valid;
    logic              wen;
    logic [RA_W-1:0]   rd;
    logic [DATA_W-1:0] res;
    flags_t            fl;
  } wb_t;

  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] of_instr;
  dec_t               of_dec;
  logic [DATA_W-1:0]  rd_a, rd_b, of_b;
  ex_t                ex_q;
  wb_t                wb_q;
  logic [DATA_W-1:0]  alu_y;
  flags_t             alu_fl;

  // Named pipeline events
  logic stall;
  logic br_taken;
  logic of_go;

  // ---------------- Fetch / operand fetch ----------------
  assign of_instr = ROM_INIT[int'(pc_q)*INSTR_W +: INSTR_W];
  assign of_dec   = decode(of_instr);

  pipe3_rf #(.W(DATA_W), .N(NREGS)) rf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (wb_q.rd),
    .wdata   (wb_q.res),
    .raddr_a (of_dec.ra),
    .raddr_b (of_dec.rb),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  assign of_b = (of_dec.op == OP_ADDI) ? DATA_W'(of_dec.imm) : rd_b;

  pipe3_hazard hz_i (
    .use_a   (of_dec.use_a),
    .use_b   (of_dec.use_b),
    .ra      (of_dec.ra),
    .rb      (of_dec.rb),
    .ex_busy (ex_q.valid && ex_q.wen),
    .ex_rd   (ex_q.rd),
    .wb_busy (wb_q.valid && wb_q.wen),
    .wb_rd   (wb_q.rd),
    .stall   (stall)
  );

  assign br_taken = ex_q.valid && (ex_q.op == OP_BZ) && alu_fl.z;
  assign of_go    = !stall && !br_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (br_taken) begin
      pc_q <= ex_q.tgt;
    end else if (!stall) begin
      pc_q <= pc_q + PC_W'(1);
    end
  end

  // ---------------- Execute ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q <= '0;
    end else if (of_go) begin
      ex_q.valid <= 1'b1;
      ex_q.op    <= of_dec.op;
      ex_q.rd    <= of_dec.rd;
      ex_q.wen   <= of_dec.wen;
      ex_q.a     <= rd_a;
      ex_q.b     <= of_b;
      ex_q.tgt   <= PC_W'(of_dec.imm);
    end else begin
      ex_q <= '0;
    end
  end

  pipe3_alu #(.W(DATA_W)) alu_i (
    .op    (ex_q.op),
    .a     (ex_q.a),
    .b     (ex_q.b),
    .y     (alu_y),
    .flags (alu_fl)
  );

  // ---------------- Writeback ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q <= '0;
    end else begin
      wb_q.valid <= ex_q.valid;
      wb_q.wen   <= ex_q.wen;
      wb_q.rd    <= ex_q.rd;
      wb_q.res   <= alu_y;
      wb_q.fl    <= alu_fl;
    end
  end

  assign rf_we        = wb_q.valid && wb_q.wen;
  assign rf_waddr     = wb_q.rd;
  assign rf_wdata     = wb_q.res;
  assign retire       = wb_q.valid;
  assign retire_flags = wb_q.fl;

  // ---------------- Assertions ----------------
  p_ex_to_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ex_q.valid |=> (wb_q.valid && wb_q.rd == $past(ex_q.rd)));

  p_stall_holds_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !br_taken) |=> pc_q == $past(pc_q));

  p_bubble_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !of_go |=> !ex_q.valid);

  p_stall_needs_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((ex_q.valid && ex_q.wen) || (wb_q.valid && wb_q.wen)));

  p_branch_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> pc_q == $past(ex_q.tgt));

  p_we_with_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> retire);

endmodule

// File: tb/pipe3_core_tb.sv
module pipe3_core_tb_top;
  import pipe3_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int LOGN = 40;

  function automatic logic [15:0] enc_r(input int op, input int rd, input int ra, input int rb);
    return {4'(op), 3'(rd), 3'(ra), 3'(rb), 3'b000};
  endfunction

  function automatic logic [15:0] enc_i(input int op, input int rd, input int ra, input int imm);
    return {4'(op), 3'(rd), 3'(ra), 6'(imm)};
  endfunction

  function automatic logic [1023:0] build_prog();
    logic [1023:0] p;
    p = '0;
    p[16*0  +: 16] = enc_i(6, 1, 0, 5);
    p[16*1  +: 16] = enc_i(6, 2, 0, 9);
    p[16*2  +: 16] = enc_i(6, 3, 0, 20);
    p[16*3  +: 16] = enc_i(6, 4, 0, 63);
    p[16*4  +: 16] = enc_r(1, 5, 1, 2);
    p[16*5  +: 16] = enc_r(2, 6, 5, 1);
    p[16*6  +: 16] = enc_r(2, 7, 1, 2);
    p[16*7  +: 16] = enc_i(6, 1, 0, 1);
    p[16*8  +: 16] = enc_r(5, 2, 2, 2);
    p[16*9  +: 16] = enc_r(4, 3, 1, 3);
    p[16*10 +: 16] = enc_r(1, 4, 4, 4);
    p[16*11 +: 16] = enc_r(1, 5, 4, 4);
    p[16*12 +: 16] = enc_r(1, 6, 5, 5);
    p[16*13 +: 16] = enc_i(7, 0, 2, 16);
    p[16*14 +: 16] = enc_i(6, 7, 0, 33);
    p[16*15 +: 16] = enc_i(6, 7, 0, 34);
    p[16*16 +: 16] = enc_i(6, 1, 0, 2);
    p[16*17 +: 16] = enc_i(7, 2, 1, 0);
    p[16*18 +: 16] = enc_i(6, 2, 2, 7);
    p[16*19 +: 16] = enc_i(7, 0, 0, 19);
    return p;
  endfunction

  localparam logic [1023:0] PROG = build_prog();

  logic          clk;
  logic          rst_n;
  logic          rf_we;
  logic [2:0]    rf_waddr;
  logic [DW-1:0] rf_wdata;
  logic          retire;
  logic [3:0]    retire_flags;

  pipe3_core #(.DATA_W(DW), .NREGS(8), .IMEM_DEPTH(64), .ROM_INIT(PROG)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rf_we        (rf_we),
    .rf_waddr     (rf_waddr),
    .rf_wdata     (rf_wdata),
    .retire       (retire),
    .retire_flags (retire_flags)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  int  cyc     = 0;

  logic          lg_ret   [LOGN+1];
  logic          lg_we    [LOGN+1];
  logic [2:0]    lg_addr  [LOGN+1];
  logic [DW-1:0] lg_data  [LOGN+1];
  logic [3:0]    lg_flags [LOGN+1];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Cycle k is the k-th cycle with reset released; the instruction at PC 0 is fetched in cycle 1.
  always @(negedge clk) begin
    if (rst_n && cyc + 1 <= LOGN) begin
      lg_ret[cyc+1]   = retire;
      lg_we[cyc+1]    = rf_we;
      lg_addr[cyc+1]  = rf_waddr;
      lg_data[cyc+1]  = rf_wdata;
      lg_flags[cyc+1] = retire_flags;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic exp_write(input int c, input int addr, input int data, input string req);
    chk(req, $sformatf("retire c%0d", c), longint'(lg_ret[c]), 1);
    chk(req, $sformatf("we c%0d", c), longint'(lg_we[c]), 1);
    chk(req, $sformatf("addr c%0d", c), longint'(lg_addr[c]), longint'(addr));
    chk(req, $sformatf("data c%0d", c), longint'(lg_data[c]), longint'(data));
  endtask

  task automatic exp_nowrite(input int c, input string req);
    chk(req, $sformatf("retire c%0d", c), longint'(lg_ret[c]), 1);
    chk(req, $sformatf("we c%0d", c), longint'(lg_we[c]), 0);
  endtask

  task automatic exp_bubble(input int c, input string req);
    chk(req, $sformatf("no retire c%0d", c), longint'(lg_ret[c]), 0);
    chk(req, $sformatf("no we c%0d", c), longint'(lg_we[c]), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R2", "retire in reset", longint'(retire), 0);
    chk("R2", "we in reset", longint'(rf_we), 0);
  endtask

  task automatic t_fill();
    exp_bubble(1, "R1");
    exp_bubble(2, "R1");
    exp_write(3, 1, 5, "R1");
    exp_write(4, 2, 9, "R1");
    exp_write(5, 3, 20, "R1");
    exp_write(6, 4, 63, "R1");
    exp_write(7, 5, 14, "R2");
  endtask

  task automatic t_adjacent_dep();
    exp_bubble(8, "R3");
    exp_bubble(9, "R4");
    exp_write(10, 6, 9, "R3");
    exp_write(16, 4, 126, "R1");
    exp_bubble(17, "R3");
    exp_bubble(18, "R4");
    exp_write(19, 5, 252, "R3");
    exp_bubble(20, "R3");
    exp_bubble(21, "R4");
    exp_write(22, 6, 248, "R3");
  endtask

  task automatic t_gap_dep();
    exp_write(11, 7, 252, "R8");
    exp_write(12, 1, 1, "R8");
    exp_write(13, 2, 0, "R8");
    exp_bubble(14, "R3");
    exp_write(15, 3, 21, "R3");
  endtask

  task automatic t_flags();
    chk("R9", "flags add small", longint'(lg_flags[3]), 4'b0000);
    chk("R9", "flags sub borrow", longint'(lg_flags[11]), 4'b0110);
    chk("R9", "flags xor zero", longint'(lg_flags[13]), 4'b0001);
    chk("R9", "flags add overflow", longint'(lg_flags[19]), 4'b1010);
    chk("R9", "flags add carry", longint'(lg_flags[22]), 4'b0110);
  endtask

  task automatic t_branch_taken();
    exp_nowrite(23, "R6");
    chk("R6", "branch flags", longint'(lg_flags[23]), 4'b0001);
    exp_bubble(24, "R6");
    exp_write(25, 1, 2, "R6");
    // squashed/skipped writes to r7 must never appear
    for (int c = 12; c <= LOGN; c++)
      if (lg_ret[c] && lg_we[c])
        chk("R6", $sformatf("no r7 write c%0d", c), longint'(lg_addr[c] == 3'd7), 0);
  endtask

  task automatic t_branch_not_taken();
    exp_bubble(26, "R3");
    exp_bubble(27, "R3");
    exp_nowrite(28, "R7");
    exp_write(29, 2, 7, "R5");
  endtask

  task automatic t_loop();
    exp_nowrite(30, "R6");
    exp_bubble(31, "R10");
    exp_nowrite(32, "R6");
    exp_bubble(33, "R10");
    exp_nowrite(34, "R10");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    rst_n = 1'b1;
    repeat (LOGN + 2) @(posedge clk);
    @(negedge clk);
    t_fill();
    t_adjacent_dep();
    t_gap_dep();
    t_flags();
    t_branch_taken();
    t_branch_not_taken();
    t_loop();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule